// File: doc/BRIEF.md
# Repeated String Transfer Sequencer

This block carries out one string instruction at a time: a move, a store or a load, working on bytes or on 16-bit words, with or without a repeat prefix. A pulse on `start` captures the operation, the source and destination offsets, the element count, the two segment bases, the direction bit and the accumulator. The block then issues single-element memory requests over a port that uses a valid/ready handshake. Each request carries a segment and an offset. Reads always go to the data segment at the source offset. Writes always go to the extra segment at the destination offset.

After each element has completed, the block steps the offsets that the operation uses. When the repeat prefix is set, it also decrements the count. It stops once the count reaches zero, or after a single element when there is no repeat prefix. A one-cycle `done` pulse then reports the updated offsets, count and accumulator. A repeated operation that starts with a count of zero finishes at once and makes no access.

Top module: `str_xfer_seq`

## Requirements
- R1: Operation code 0 (and the spare code 3) is a move: for each element, the block first issues a read at segment `ds_init` and the current source offset, then a write at segment `es_init` and the current destination offset. The write carries the value just read.
- R2: Once an element completes, each offset that the operation uses changes by 1 when `wide_sel` is 0 (byte) and by 2 when `wide_sel` is 1 (word).
- R3: With `dir_sel` at 0 the offsets grow; with `dir_sel` at 1 they shrink.
- R4: With `rep_sel` at 1, the count drops by one for each completed element and the operation ends when it reaches zero, so `cx_out` reads 0 at `done`.
- R5: With `rep_sel` at 1 and `cx_init` equal to zero, `done` is high in the cycle after `start` is taken and no memory request is ever issued.
- R6: With `rep_sel` at 0, exactly one element is processed and `cx_out` keeps the value captured at start.
- R7: Operation code 2 is a load: one read per element at `ds_init`:source offset. A byte load replaces only the low half of the accumulator, a word load replaces all of it, and only the source offset moves.
- R8: Operation code 1 is a store: one write per element of the accumulator at `es_init`:destination offset, and only the destination offset moves. A byte write puts the data on the low lane with the upper lane zero, for stores and moves alike. A byte read uses only the low lane of `mem_rdata`.
- R9: A request that is not accepted keeps valid, direction, size, segment, offset and write data unchanged until `mem_ready` is seen. Offsets and count change only after the access has completed.
- R10: Offset arithmetic wraps modulo 2^16.
- R11: After reset, busy, done, the request valid and all register outputs are zero. `busy` is high from the cycle after `start` is taken through the `done` cycle. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; taken only while idle |
| op_sel | input | 2 | 0 move, 1 store, 2 load, 3 move |
| wide_sel | input | 1 | 0 byte elements, 1 word elements |
| rep_sel | input | 1 | Repeat under count control |
| dir_sel | input | 1 | 0 step up, 1 step down |
| si_init | input | W | Starting source offset |
| di_init | input | W | Starting destination offset |
| cx_init | input | W | Starting element count |
| ds_init | input | W | Segment used for reads |
| es_init | input | W | Segment used for writes |
| acc_init | input | W | Starting accumulator |
| mem_valid | output | 1 | Request valid |
| mem_write | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | Request is a word access |
| mem_seg | output | W | Request segment |
| mem_off | output | W | Request offset |
| mem_wdata | output | W | Write data, low lane for bytes |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | W | Read data, valid in the accepting cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| si_out | output | W | Current source offset |
| di_out | output | W | Current destination offset |
| cx_out | output | W | Current count |
| acc_out | output | W | Current accumulator |

## Verification
On every cycle the assertions check the following: a stalled request stays stable, reads go to the data segment and writes to the extra segment, each completed element moves the offsets by the signed step, the count drops by one under repeat, the count stays fixed without repeat, a zero-count repeat ends at once, and `done` lasts one cycle. Some behaviour is visible only across a whole scenario in the bench: the full order of addresses in a run, the value a move carries from its read to its write, byte-lane masking, keeping the upper accumulator byte on a byte load, and the final offsets after wrap-around. Those are checked against a reference model that replays each operation request by request while the memory inserts irregular stalls.

// File: rtl/str_seq_pkg.sv
package str_seq_pkg;

  typedef enum logic [1:0] {
    OP_MOVE  = 2'd0,
    OP_STORE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_SPARE = 2'd3
  } xfer_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WR   = 3'd2,
    ST_ADV  = 3'd3,
    ST_DONE = 3'd4
  } seq_state_e;

  // Operations that read a source element (spare code behaves as move)
  function automatic logic reads_source(input xfer_op_e op);
    return op != OP_STORE;
  endfunction

  // Operations that write a destination element
  function automatic logic writes_dest(input xfer_op_e op);
    return op != OP_LOAD;
  endfunction

endpackage

// File: rtl/str_seq_fsm.sv
module str_seq_fsm
  import str_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  xfer_op_e   op_sel,
  input  logic       rep_sel,
  input  logic       cx_init_zero,
  input  xfer_op_e   op_q,
  input  logic       mem_ready,
  input  logic       last_elem,
  output seq_state_e state,
  output logic       accept,
  output logic       rd_hs,
  output logic       adv,
  output logic       done,
  output logic       busy
);

  seq_state_e nxt;

  always_comb begin
    nxt    = state;
    accept = 1'b0;
    rd_hs  = 1'b0;
    adv    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          if (rep_sel && cx_init_zero)   nxt = ST_DONE;
          else if (reads_source(op_sel)) nxt = ST_RD;
          else                           nxt = ST_WR;
        end
      end
      ST_RD: begin
        if (mem_ready) begin
          rd_hs = 1'b1;
          nxt   = writes_dest(op_q) ? ST_WR : ST_ADV;
        end
      end
      ST_WR: begin
        if (mem_ready) nxt = ST_ADV;
      end
      ST_ADV: begin
        adv = 1'b1;
        if (last_elem)              nxt = ST_DONE;
        else if (reads_source(op_q)) nxt = ST_RD;
        else                         nxt = ST_WR;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign done = (state == ST_DONE);
  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/str_seq_regs.sv
module str_seq_regs
  import str_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  xfer_op_e     op_sel,
  input  logic         wide_sel,
  input  logic         rep_sel,
  input  logic         dir_sel,
  input  logic [W-1:0] si_init,
  input  logic [W-1:0] di_init,
  input  logic [W-1:0] cx_init,
  input  logic [W-1:0] ds_init,
  input  logic [W-1:0] es_init,
  input  logic [W-1:0] acc_init,
  input  logic         rd_hs,
  input  logic [W-1:0] rdata,
  input  logic         adv,
  output xfer_op_e     op_q,
  output logic         wide_q,
  output logic         rep_q,
  output logic         dir_q,
  output logic [W-1:0] si_q,
  output logic [W-1:0] di_q,
  output logic [W-1:0] cx_q,
  output logic [W-1:0] ds_q,
  output logic [W-1:0] es_q,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] buf_q,
  output logic         last_elem
);

  localparam int HW   = W / 2;
  localparam int NPTR = 2;

  // Signed step for one element, modulo 2^W
  function automatic logic [W-1:0] ptr_step(input logic [W-1:0] p,
                                            input logic wide,
                                            input logic dir);
    logic [W-1:0] d;
    d = wide ? W'(2) : W'(1);
    return dir ? (p - d) : (p + d);
  endfunction

  logic [W-1:0] ptr_q    [NPTR];
  logic [W-1:0] ptr_init [NPTR];
  logic         ptr_used [NPTR];

  assign ptr_init[0] = si_init;
  assign ptr_init[1] = di_init;
  assign ptr_used[0] = reads_source(op_q);
  assign ptr_used[1] = writes_dest(op_q);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ptr_q[g] <= '0;
      else if (accept)             ptr_q[g] <= ptr_init[g];
      else if (adv && ptr_used[g]) ptr_q[g] <= ptr_step(ptr_q[g], wide_q, dir_q);
    end
  end

  assign si_q = ptr_q[0];
  assign di_q = ptr_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_MOVE;
      wide_q <= 1'b0;
      rep_q  <= 1'b0;
      dir_q  <= 1'b0;
      cx_q   <= '0;
      ds_q   <= '0;
      es_q   <= '0;
      acc_q  <= '0;
      buf_q  <= '0;
    end else if (accept) begin
      op_q   <= op_sel;
      wide_q <= wide_sel;
      rep_q  <= rep_sel;
      dir_q  <= dir_sel;
      cx_q   <= cx_init;
      ds_q   <= ds_init;
      es_q   <= es_init;
      acc_q  <= acc_init;
    end else begin
      if (rd_hs) begin
        buf_q <= wide_q ? rdata : {{(W-HW){1'b0}}, rdata[HW-1:0]};
        if (op_q == OP_LOAD)
          acc_q <= wide_q ? rdata : {acc_q[W-1:HW], rdata[HW-1:0]};
      end
      if (adv && rep_q) cx_q <= cx_q - W'(1);
    end
  end

  assign last_elem = !rep_q || (cx_q == W'(1));

endmodule

// File: rtl/str_seq_req.sv
module str_seq_req
  import str_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  seq_state_e   state,
  input  xfer_op_e     op_q,
  input  logic         wide_q,
  input  logic [W-1:0] si_q,
  input  logic [W-1:0] di_q,
  input  logic [W-1:0] ds_q,
  input  logic [W-1:0] es_q,
  input  logic [W-1:0] acc_q,
  input  logic [W-1:0] buf_q,
  output logic         mem_valid,
  output logic         mem_write,
  output logic         mem_wide,
  output logic [W-1:0] mem_seg,
  output logic [W-1:0] mem_off,
  output logic [W-1:0] mem_wdata
);

  localparam int HW = W / 2;

  logic [W-1:0] wsrc;

  assign mem_valid = (state == ST_RD) || (state == ST_WR);
  assign mem_write = (state == ST_WR);
  assign mem_wide  = wide_q;
  assign mem_seg   = mem_write ? es_q : ds_q;
  assign mem_off   = mem_write ? di_q : si_q;
  assign wsrc      = reads_source(op_q) ? buf_q : acc_q;
  assign mem_wdata = wide_q ? wsrc : {{(W-HW){1'b0}}, wsrc[HW-1:0]};

endmodule

// File: rtl/str_xfer_seq.sv
module str_xfer_seq
  import str_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op_sel,
  input  logic         wide_sel,
  input  logic         rep_sel,
  input  logic         dir_sel,
  input  logic [W-1:0] si_init,
  input  logic [W-1:0] di_init,
  input  logic [W-1:0] cx_init,
  input  logic [W-1:0] ds_init,
  input  logic [W-1:0] es_init,
  input  logic [W-1:0] acc_init,
  output logic         mem_valid,
  output logic         mem_write,
  output logic         mem_wide,
  output logic [W-1:0] mem_seg,
  output logic [W-1:0] mem_off,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_ready,
  input  logic [W-1:0] mem_rdata,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] si_out,
  output logic [W-1:0] di_out,
  output logic [W-1:0] cx_out,
  output logic [W-1:0] acc_out
);

  xfer_op_e     op_in;
  xfer_op_e     op_q;
  seq_state_e   state;
  logic         accept, rd_hs, adv_evt, last_elem;
  logic         wide_q, rep_q, dir_q;
  logic [W-1:0] si_q, di_q, cx_q, ds_q, es_q, acc_q, buf_q;

  assign op_in = xfer_op_e'(op_sel);

  str_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .op_sel       (op_in),
    .rep_sel      (rep_sel),
    .cx_init_zero (cx_init == '0),
    .op_q         (op_q),
    .mem_ready    (mem_ready),
    .last_elem    (last_elem),
    .state        (state),
    .accept       (accept),
    .rd_hs        (rd_hs),
    .adv          (adv_evt),
    .done         (done),
    .busy         (busy)
  );

  str_seq_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .op_sel    (op_in),
    .wide_sel  (wide_sel),
    .rep_sel   (rep_sel),
    .dir_sel   (dir_sel),
    .si_init   (si_init),
    .di_init   (di_init),
    .cx_init   (cx_init),
    .ds_init   (ds_init),
    .es_init   (es_init),
    .acc_init  (acc_init),
    .rd_hs     (rd_hs),
    .rdata     (mem_rdata),
    .adv       (adv_evt),
    .op_q      (op_q),
    .wide_q    (wide_q),
    .rep_q     (rep_q),
    .dir_q     (dir_q),
    .si_q      (si_q),
    .di_q      (di_q),
    .cx_q      (cx_q),
    .ds_q      (ds_q),
    .es_q      (es_q),
    .acc_q     (acc_q),
    .buf_q     (buf_q),
    .last_elem (last_elem)
  );

  str_seq_req #(.W(W)) u_req (
    .state     (state),
    .op_q      (op_q),
    .wide_q    (wide_q),
    .si_q      (si_q),
    .di_q      (di_q),
    .ds_q      (ds_q),
    .es_q      (es_q),
    .acc_q     (acc_q),
    .buf_q     (buf_q),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_wide  (mem_wide),
    .mem_seg   (mem_seg),
    .mem_off   (mem_off),
    .mem_wdata (mem_wdata)
  );

  assign si_out  = si_q;
  assign di_out  = di_q;
  assign cx_out  = cx_q;
  assign acc_out = acc_q;

endmodule

// File: rtl/str_xfer_seq_chk.sv
module str_xfer_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         accept,
  input logic         rep_sel,
  input logic [W-1:0] cx_init,
  input logic         adv_evt,
  input logic [1:0]   op_q,
  input logic         wide_q,
  input logic         rep_q,
  input logic         dir_q,
  input logic [W-1:0] si_q,
  input logic [W-1:0] di_q,
  input logic [W-1:0] cx_q,
  input logic [W-1:0] ds_q,
  input logic [W-1:0] es_q,
  input logic         mem_valid,
  input logic         mem_write,
  input logic         mem_wide,
  input logic [W-1:0] mem_seg,
  input logic [W-1:0] mem_off,
  input logic [W-1:0] mem_wdata,
  input logic         mem_ready,
  input logic         busy,
  input logic         done
);

  // R9: a stalled request does not move
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write) && $stable(mem_wide)
      && $stable(mem_seg) && $stable(mem_off) && $stable(mem_wdata));

  // R1, R7: reads use the data segment at the source offset
  assert_read_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write |-> mem_seg == ds_q && mem_off == si_q);

  // R8: writes use the extra segment at the destination offset
  assert_write_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> mem_seg == es_q && mem_off == di_q);

  // R2, R3, R10: source offset step, modulo 2^W
  assert_src_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && op_q != 2'd1 && !dir_q |=> si_q == $past(si_q) + ($past(wide_q) ? W'(2) : W'(1)));

  assert_src_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && op_q != 2'd1 && dir_q |=> si_q == $past(si_q) - ($past(wide_q) ? W'(2) : W'(1)));

  // R2, R3, R10: destination offset step
  assert_dst_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && op_q != 2'd2 && !dir_q |=> di_q == $past(di_q) + ($past(wide_q) ? W'(2) : W'(1)));

  assert_dst_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && op_q != 2'd2 && dir_q |=> di_q == $past(di_q) - ($past(wide_q) ? W'(2) : W'(1)));

  // R7: a load leaves the destination offset alone
  assert_load_di_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && op_q == 2'd2 |=> $stable(di_q));

  // R8: a store leaves the source offset alone
  assert_store_si_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && op_q == 2'd1 |=> $stable(si_q));

  // R4: one count per completed element under repeat
  assert_count_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && rep_q |=> cx_q == $past(cx_q) - W'(1));

  // R6: no repeat, count frozen
  assert_count_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rep_q |=> $stable(cx_q));

  // R5: zero-count repeat finishes straight away without access
  assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && rep_sel && cx_init == '0 |=> done && !mem_valid);

  // R11: single-cycle done, inside busy
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && !mem_valid);

endmodule

bind str_xfer_seq str_xfer_seq_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .rep_sel   (rep_sel),
  .cx_init   (cx_init),
  .adv_evt   (adv_evt),
  .op_q      (op_q),
  .wide_q    (wide_q),
  .rep_q     (rep_q),
  .dir_q     (dir_q),
  .si_q      (si_q),
  .di_q      (di_q),
  .cx_q      (cx_q),
  .ds_q      (ds_q),
  .es_q      (es_q),
  .mem_valid (mem_valid),
  .mem_write (mem_write),
  .mem_wide  (mem_wide),
  .mem_seg   (mem_seg),
  .mem_off   (mem_off),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .busy      (busy),
  .done      (done)
);

// File: tb/sim_str_xfer_seq.sv
module sim_str_xfer_seq;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op_sel = '0;
  logic          wide_sel = 1'b0, rep_sel = 1'b0, dir_sel = 1'b0;
  logic [W-1:0]  si_init = '0, di_init = '0, cx_init = '0;
  logic [W-1:0]  ds_init = '0, es_init = '0, acc_init = '0;
  logic          mem_valid, mem_write, mem_wide;
  logic [W-1:0]  mem_seg, mem_off, mem_wdata;
  logic          mem_ready = 1'b0;
  logic [W-1:0]  mem_rdata = '0;
  logic          busy, done;
  logic [W-1:0]  si_out, di_out, cx_out, acc_out;

  always #4 clk = ~clk;

  str_xfer_seq #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .wide_sel(wide_sel), .rep_sel(rep_sel), .dir_sel(dir_sel),
    .si_init(si_init), .di_init(di_init), .cx_init(cx_init),
    .ds_init(ds_init), .es_init(es_init), .acc_init(acc_init),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_wide(mem_wide),
    .mem_seg(mem_seg), .mem_off(mem_off), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .done(done),
    .si_out(si_out), .di_out(di_out), .cx_out(cx_out), .acc_out(acc_out)
  );

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  logic [15:0] lf = 16'hACE1;

  typedef struct {
    logic [63:0] fields;
  } exp_req_t;

  exp_req_t expq[$];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_err++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  // Word at seg:off, little-endian; a byte read still sees a busy upper lane
  function automatic logic [15:0] rd_word(input logic [15:0] seg, input logic [15:0] off);
    logic [19:0] p;
    p = phys(seg, off);
    return {mem_byte(p + 20'd1), mem_byte(p)};
  endfunction

  function automatic logic [63:0] pack_req(input logic wr, input logic wd,
      input logic [15:0] seg, input logic [15:0] off, input logic [15:0] data);
    return {14'd0, wr, wd, seg, off, (wr ? data : 16'h0000)};
  endfunction

  function automatic logic [63:0] port_req();
    return pack_req(mem_write, mem_wide, mem_seg, mem_off, mem_wdata);
  endfunction

  function automatic void lf_step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endfunction

  task automatic run(input string tag, input logic [1:0] op, input logic wd,
                     input logic rp, input logic dr, input logic [15:0] si,
                     input logic [15:0] di, input logic [15:0] cx,
                     input logic [15:0] acc, input logic [15:0] ds,
                     input logic [15:0] es);
    logic [15:0] s, d, c, a, v, w, stp;
    logic [63:0] held;
    exp_req_t    e;
    int          nel, done_t;
    bit          stall;
    s = si; d = di; c = cx; a = acc;
    stp = wd ? 16'd2 : 16'd1;
    nel = rp ? int'(cx) : 1;
    expq.delete();
    for (int k = 0; k < nel; k++) begin
      v = 16'h0000;
      if (op != 2'd1) begin
        v = rd_word(ds, s);
        e.fields = pack_req(1'b0, wd, ds, s, 16'h0000);
        expq.push_back(e);
        if (op == 2'd2) a = wd ? v : {a[15:8], v[7:0]};
      end
      if (op != 2'd2) begin
        w = (op == 2'd1) ? a : v;
        if (!wd) w = {8'h00, w[7:0]};
        e.fields = pack_req(1'b1, wd, es, d, w);
        expq.push_back(e);
      end
      if (op != 2'd1) s = dr ? s - stp : s + stp;
      if (op != 2'd2) d = dr ? d - stp : d + stp;
      if (rp) c = c - 16'd1;
    end

    @(negedge clk);
    op_sel = op; wide_sel = wd; rep_sel = rp; dir_sel = dr;
    si_init = si; di_init = di; cx_init = cx; acc_init = acc;
    ds_init = ds; es_init = es;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    done_t = -1;
    stall  = 1'b0;
    held   = '0;
    for (int t = 0; t < 4000; t++) begin
      if (stall)
        chk("R9", {mem_valid, port_req()}, {1'b1, held}, "stalled request changed");
      if (done) begin
        done_t = t;
        break;
      end
      lf_step();
      if (mem_valid) begin
        mem_ready = lf[0] | lf[1];
        stall = !mem_ready;
        held  = port_req();
        if (mem_ready) begin
          if (expq.size() == 0) begin
            n_checks++;
            n_err++;
            $display("FAIL %s unexpected request actual=%h expected=none", tag, port_req());
          end else begin
            e = expq.pop_front();
            chk(tag, port_req(), e.fields, "request");
          end
          mem_rdata = rd_word(mem_seg, mem_off);
        end
      end else begin
        mem_ready = lf[2];
        stall = 1'b0;
      end
      @(negedge clk);
    end

    chk(tag, 64'(done_t >= 0), 64'd1, "done seen");
    if (rp && cx == 16'd0) chk("R5", 64'(done_t), 64'd0, "cycles to done on zero count");
    chk("R11", 64'(busy), 64'd1, "busy during done");
    chk(tag, 64'(expq.size()), 64'd0, "requests still pending");
    chk(tag, 64'(si_out), 64'(s), "final source offset");
    chk(tag, 64'(di_out), 64'(d), "final destination offset");
    chk(tag, 64'(cx_out), 64'(c), "final count");
    chk(tag, 64'(acc_out), 64'(a), "final accumulator");
    mem_ready = 1'b0;
    @(negedge clk);
    chk("R11", {62'd0, done, busy}, 64'd0, "done and busy after pulse");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {busy, done, mem_valid, si_out, di_out, cx_out}, '0, "reset outputs");
    chk("R11", 64'(acc_out), 64'd0, "reset accumulator");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 byte move, repeat, upward
    run("R1", 2'd0, 1'b0, 1'b1, 1'b0, 16'h0010, 16'h0200, 16'd4, 16'h0000, 16'h1000, 16'h2000);
    // R2 word move, repeat, upward
    run("R2", 2'd0, 1'b1, 1'b1, 1'b0, 16'h0100, 16'h0300, 16'd3, 16'h0000, 16'h1200, 16'h3400);
    // R3 word move, repeat, downward
    run("R3", 2'd0, 1'b1, 1'b1, 1'b1, 16'h0120, 16'h0340, 16'd3, 16'h0000, 16'h0800, 16'h0900);
    // R4 byte store, repeat count 5
    run("R4", 2'd1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0400, 16'd5, 16'h1234, 16'h0000, 16'h5000);
    // R5 zero count with repeat: no access
    run("R5", 2'd0, 1'b1, 1'b1, 1'b0, 16'h0040, 16'h0080, 16'd0, 16'h0000, 16'h1000, 16'h2000);
    // R6 no repeat: one element, count kept
    run("R6", 2'd0, 1'b0, 1'b0, 1'b1, 16'h0050, 16'h0060, 16'd7, 16'h0000, 16'h0123, 16'h0456);
    // R7 byte load keeps upper accumulator byte; word load with repeat
    run("R7", 2'd2, 1'b0, 1'b0, 1'b0, 16'h0031, 16'h0777, 16'd9, 16'hAB12, 16'h0F00, 16'h0000);
    run("R7", 2'd2, 1'b1, 1'b1, 1'b1, 16'h0090, 16'h0777, 16'd2, 16'h0000, 16'h0F00, 16'h0000);
    // R8 word store, no repeat, downward
    run("R8", 2'd1, 1'b1, 1'b0, 1'b1, 16'h0011, 16'h0600, 16'd3, 16'hBEEF, 16'h0000, 16'h7000);
    // R10 wrap-around on both ends
    run("R10", 2'd0, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0001, 16'd2, 16'h0000, 16'h2000, 16'h3000);
    run("R10", 2'd1, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h0001, 16'd2, 16'hC0DE, 16'h0000, 16'h3000);
    // R1 spare code acts as move
    run("R1", 2'd3, 1'b0, 1'b1, 1'b1, 16'h0003, 16'h0002, 16'd3, 16'h0000, 16'h4000, 16'h4000);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule